// File: doc/BRIEF.md
# Multi-Drop Backplane Bus Slave Node

This block is the slave end of one compute node on a shared backplane bus that has a single master and no arbiter. The master presents a 16-bit address, a strobe and a read/write select; a 64-bit bidirectional data bus carries write data from the master and read data back from exactly one node. No interrupts exist: the master learns anything about a node only by reading from it.

Each node takes its identity from two static inputs, the number of the module it sits on and its position on that module. Every node runs the same logic. The address holds a module field, a position field and a register index. A zero in the module field or in the position field acts as a wildcard for writes. This lets the master write to one node, to every node on one module, to one position on all modules, or to every node at once. Each node has a bank of 32 test registers of 64 bits. Reads are single-target only. A node turns on its data bus drivers only for a read addressed exactly to itself and keeps them at high impedance at all other times.

Top module: `bus_node_slave`

## Requirements
- R1: After reset every test register reads back as zero and the drive enable is low.
- R2: A write strobe whose module field (address bits 15:11) equals the node's module number and whose position field (bits 10:8) equals its position stores the data bus into the register selected by the index field (bits 7:0).
- R3: A module field of zero matches every module and a position field of zero matches every position for writes, so address module 0, position 0 writes the register on every node.
- R4: A write with the node's own module number and position field zero, or module field zero and the node's own position, updates the node.
- R5: A write whose non-zero module or non-zero position field differs from the node's identity leaves all of the node's registers unchanged.
- R6: The node drives the data bus only while the strobe is high with read selected and both fields match its identity exactly; reads to wildcard or foreign addresses leave the drive enable low.
- R7: Read data and the drive enable appear one clock after the read strobe is first sampled high, and the driven value stays constant while the strobe stays high.
- R8: The drive enable falls in the same cycle as the strobe falls, with no clock edge in between, so a write in the next cycle never meets a driving node.
- R9: An index field of 32 or more selects no register: such writes change nothing and such reads are not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modId | input | 5 | Module number of the slot, 1 to 31 |
| posId | input | 3 | Position of the node on its module, non-zero |
| busAddr | input | 16 | Module, position and register index fields |
| busStrobe | input | 1 | Access strobe from the master |
| busRead | input | 1 | 1 selects a read, 0 a write |
| dataBus | inout | 64 | Shared data bus; driven only during an exact-match read |
| driveEn | output | 1 | High while the node drives the data bus |

## Verification
The two functions that share a cycle are the release of the read drive and the start of the next access: the master drops the strobe of a read and, one cycle later, raises it again for a write with its own data on the bus. The bench provokes this after every read, both in directed sequences and in constrained-random traffic that mixes exact, group, broadcast, foreign and out-of-range addresses. It judges the outcome by requiring the drive enable to be low in the very cycle the strobe falls. It then requires the following write to land exactly where a bench model of the wildcard matching says it should, as seen by later exact reads.

// File: rtl/bus_node_pkg.sv
package bus_node_pkg;
  typedef struct packed {
    logic wrEn;      // store write data into the indexed register
    logic rdLoad;    // capture the indexed register for a read
    logic rdActive;  // read data may be driven onto the bus
  } nodeCtl_t;
endpackage

// File: rtl/node_ctrl.sv
module node_ctrl
  import bus_node_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int MOD_W  = 5,
  parameter int POS_W  = 3,
  parameter int NREGS  = 32,
  localparam int IDX_W   = $clog2(NREGS),
  localparam int MOD_LSB = ADDR_W - MOD_W,
  localparam int POS_LSB = MOD_LSB - POS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MOD_W-1:0]  modId,
  input  logic [POS_W-1:0]  posId,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busStrobe,
  input  logic              busRead,
  output nodeCtl_t          ctl,
  output logic [IDX_W-1:0]  regIdx
);
  logic [MOD_W-1:0]   modField;
  logic [POS_W-1:0]   posField;
  logic [POS_LSB-1:0] idxField;
  logic inRange, exactHit, groupHit, driveQ;

  assign modField = busAddr[ADDR_W-1:MOD_LSB];
  assign posField = busAddr[MOD_LSB-1:POS_LSB];
  assign idxField = busAddr[POS_LSB-1:0];
  assign regIdx   = idxField[IDX_W-1:0];

  always_comb begin
    inRange  = (idxField < POS_LSB'(NREGS));
    exactHit = inRange && (modField == modId) && (posField == posId);
    groupHit = inRange && (modField == '0 || modField == modId)
                       && (posField == '0 || posField == posId);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           driveQ <= 1'b0;
    else if (!busStrobe) driveQ <= 1'b0;
    else if (ctl.rdLoad) driveQ <= 1'b1;
  end

  always_comb begin
    ctl.wrEn     = busStrobe && !busRead && groupHit;
    ctl.rdLoad   = busStrobe && busRead && exactHit && !driveQ;
    ctl.rdActive = driveQ && busStrobe;
  end
endmodule

// File: rtl/node_regs.sv
module node_regs
  import bus_node_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NREGS  = 32,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  nodeCtl_t          ctl,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] bank [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          bank[i] <= '0;
      else if (ctl.wrEn && regIdx == i)   bank[i] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rdData <= '0;
    else if (ctl.rdLoad) rdData <= bank[regIdx];
  end
endmodule

// File: rtl/bus_node_slave.sv
module bus_node_slave
  import bus_node_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 16,
  parameter int MOD_W  = 5,
  parameter int POS_W  = 3,
  parameter int NREGS  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MOD_W-1:0]  modId,
  input  logic [POS_W-1:0]  posId,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busStrobe,
  input  logic              busRead,
  inout  wire  [DATA_W-1:0] dataBus,
  output logic              driveEn
);
  localparam int IDX_W = $clog2(NREGS);

  nodeCtl_t          ctl;
  logic [IDX_W-1:0]  regIdx;
  logic [DATA_W-1:0] rdData;

  node_ctrl #(.ADDR_W(ADDR_W), .MOD_W(MOD_W), .POS_W(POS_W), .NREGS(NREGS)) ctrl_i (
    .clk(clk), .rstN(rstN), .modId(modId), .posId(posId), .busAddr(busAddr),
    .busStrobe(busStrobe), .busRead(busRead), .ctl(ctl), .regIdx(regIdx)
  );

  node_regs #(.DATA_W(DATA_W), .NREGS(NREGS)) regs_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .regIdx(regIdx),
    .wrData(dataBus), .rdData(rdData)
  );

  assign driveEn = ctl.rdActive;
  assign dataBus = ctl.rdActive ? rdData : {DATA_W{1'bz}};
endmodule

// File: rtl/bus_node_slave_chk.sv
module bus_node_slave_chk #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 16,
  parameter int MOD_W  = 5,
  parameter int POS_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [MOD_W-1:0]  modId,
  input logic [POS_W-1:0]  posId,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busStrobe,
  input logic              busRead,
  input logic [DATA_W-1:0] dataBus,
  input logic              driveEn
);
  localparam int MOD_LSB = ADDR_W - MOD_W;
  localparam int POS_LSB = MOD_LSB - POS_W;

  // R1: drivers are off in the cycle after any reset cycle
  assert_reset_off_R1: assert property (@(posedge clk) !rstN |=> !driveEn);

  // R6: driving implies a strobed read with an exact identity match
  assert_drive_exact_R6: assert property (@(posedge clk) disable iff (!rstN)
    driveEn |-> (busStrobe && busRead
                 && busAddr[ADDR_W-1:MOD_LSB] == modId
                 && busAddr[MOD_LSB-1:POS_LSB] == posId));

  // R7: no drive in the first cycle of a strobe
  assert_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busStrobe) |-> !driveEn);

  // R7: driven value is held while the drive continues
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (driveEn && $past(driveEn)) |-> $stable(dataBus));

  // R8: a low strobe never coexists with an active drive
  assert_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busStrobe |-> !driveEn);
endmodule

bind bus_node_slave bus_node_slave_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MOD_W(MOD_W), .POS_W(POS_W)
) chk_i (
  .clk(clk), .rstN(rstN), .modId(modId), .posId(posId), .busAddr(busAddr),
  .busStrobe(busStrobe), .busRead(busRead), .dataBus(dataBus), .driveEn(driveEn)
);

// File: tb/bus_node_slave_tb_top.sv
module bus_node_slave_tb_top;
  localparam logic [4:0] MY_MOD = 5'd17;
  localparam logic [2:0] MY_POS = 3'd3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busStrobe = 1'b0;
  logic        busRead = 1'b0;
  logic        tbDrive = 1'b0;
  logic [63:0] tbData = '0;
  wire  [63:0] dataBus;
  logic        driveEn;
  int          checks = 0;
  int          errors = 0;
  logic [63:0] model [32];

  assign dataBus = tbDrive ? tbData : 64'bz;
  always #5 clk = ~clk;

  bus_node_slave dut_i (
    .clk(clk), .rstN(rstN), .modId(MY_MOD), .posId(MY_POS), .busAddr(busAddr),
    .busStrobe(busStrobe), .busRead(busRead), .dataBus(dataBus), .driveEn(driveEn)
  );

  function automatic logic [15:0] mkAddr(logic [4:0] m, logic [2:0] p, logic [7:0] idx);
    return {m, p, idx};
  endfunction

  function automatic bit wrHits(logic [15:0] a);
    return (a[15:11] == 0 || a[15:11] == MY_MOD) && (a[10:8] == 0 || a[10:8] == MY_POS)
           && a[7:0] < 8'd32;
  endfunction

  function automatic bit rdHits(logic [15:0] a);
    return a[15:11] == MY_MOD && a[10:8] == MY_POS && a[7:0] < 8'd32;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(logic [15:0] a, logic [63:0] d);
    @(negedge clk);
    busAddr = a; busRead = 1'b0; tbData = d; tbDrive = 1'b1; busStrobe = 1'b1;
    #1 check(!driveEn, "R8 drive during write", 64'(driveEn), 64'd0);
    @(negedge clk);
    busStrobe = 1'b0; tbDrive = 1'b0;
    if (wrHits(a)) model[a[4:0]] = d;
  endtask

  task automatic doRead(logic [15:0] a, string tag);
    bit          expDrive;
    logic [63:0] first;
    expDrive = rdHits(a);
    @(negedge clk);
    busAddr = a; busRead = 1'b1; busStrobe = 1'b1;
    #1 check(!driveEn, {tag, " R7 latency"}, 64'(driveEn), 64'd0);
    @(negedge clk);
    check(driveEn == expDrive, {tag, " R6 drive enable"}, 64'(driveEn), 64'(expDrive));
    first = dataBus;
    if (expDrive) check(dataBus == model[a[4:0]], {tag, " data"}, dataBus, model[a[4:0]]);
    @(negedge clk);
    if (expDrive) check(driveEn && dataBus == first, {tag, " R7 hold"}, dataBus, first);
    busStrobe = 1'b0;
    #1 check(!driveEn, {tag, " R8 release"}, 64'(driveEn), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check(!driveEn, "R1 reset drive", 64'(driveEn), 64'd0);
    rstN = 1'b1;
    // R1: reset contents at both ends of the bank
    doRead(mkAddr(MY_MOD, MY_POS, 8'd0), "R1 reg0");
    doRead(mkAddr(MY_MOD, MY_POS, 8'd31), "R1 reg31");
    // R2: exact writes at the bank boundaries, read back right after release
    doWrite(mkAddr(MY_MOD, MY_POS, 8'd0), 64'h0123_4567_89ab_cdef);
    doWrite(mkAddr(MY_MOD, MY_POS, 8'd31), 64'hfedc_ba98_7654_3210);
    doRead(mkAddr(MY_MOD, MY_POS, 8'd0), "R2 reg0");
    doRead(mkAddr(MY_MOD, MY_POS, 8'd31), "R2 reg31");
    // R3: full broadcast
    doWrite(mkAddr(5'd0, 3'd0, 8'd5), 64'haaaa_0000_5555_ffff);
    doRead(mkAddr(MY_MOD, MY_POS, 8'd5), "R3 broadcast");
    // R4: group by module and by position
    doWrite(mkAddr(MY_MOD, 3'd0, 8'd6), 64'h1111_2222_3333_4444);
    doWrite(mkAddr(5'd0, MY_POS, 8'd7), 64'h9999_8888_7777_6666);
    doRead(mkAddr(MY_MOD, MY_POS, 8'd6), "R4 module group");
    doRead(mkAddr(MY_MOD, MY_POS, 8'd7), "R4 position group");
    // R5: foreign module or position
    doWrite(mkAddr(5'd2, MY_POS, 8'd5), 64'hdead_beef_dead_beef);
    doWrite(mkAddr(MY_MOD, 3'd4, 8'd6), 64'hcafe_cafe_cafe_cafe);
    doWrite(mkAddr(5'd0, 3'd6, 8'd7), 64'hbad0_bad0_bad0_bad0);
    doRead(mkAddr(MY_MOD, MY_POS, 8'd5), "R5 foreign module");
    doRead(mkAddr(MY_MOD, MY_POS, 8'd6), "R5 foreign position");
    doRead(mkAddr(MY_MOD, MY_POS, 8'd7), "R5 foreign position wildcard module");
    // R6: wildcard and foreign reads never drive
    doRead(mkAddr(5'd0, 3'd0, 8'd5), "R6 broadcast read");
    doRead(mkAddr(MY_MOD, 3'd0, 8'd5), "R6 group read");
    doRead(mkAddr(5'd0, MY_POS, 8'd5), "R6 position read");
    doRead(mkAddr(5'd9, MY_POS, 8'd5), "R6 foreign read");
    // R9: indices beyond the bank
    doWrite(mkAddr(MY_MOD, MY_POS, 8'd32), 64'h5a5a_5a5a_5a5a_5a5a);
    doWrite(mkAddr(5'd0, 3'd0, 8'd255), 64'ha5a5_a5a5_a5a5_a5a5);
    doRead(mkAddr(MY_MOD, MY_POS, 8'd32), "R9 read idx32");
    doRead(mkAddr(MY_MOD, MY_POS, 8'd0), "R9 alias reg0");
    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [4:0] m;
      logic [2:0] p;
      logic [7:0] idx;
      case ($urandom_range(0, 2))
        0: m = 5'd0;
        1: m = MY_MOD;
        default: m = 5'($urandom_range(0, 31));
      endcase
      case ($urandom_range(0, 2))
        0: p = 3'd0;
        1: p = MY_POS;
        default: p = 3'($urandom_range(0, 7));
      endcase
      idx = ($urandom_range(0, 7) == 0) ? 8'($urandom_range(32, 255))
                                        : 8'($urandom_range(0, 31));
      if ($urandom_range(0, 1) == 0)
        doWrite(mkAddr(m, p, idx), {$urandom, $urandom});
      else
        doRead(mkAddr(m, p, idx), "R2 random read");
    end
    // final sweep of the whole bank
    for (int i = 0; i < 32; i++) doRead(mkAddr(MY_MOD, MY_POS, 8'(i)), "R2 R5 sweep");
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule